// File: doc/BRIEF.md
# CAN Message FIFO Mailbox Window

This block holds the transmit and receive message queues of a CAN controller and lets a CPU reach each queue through a single fixed mailbox window on a byte-wide register port. To send, software fills the transmit window byte by byte and then writes the key value 0xFF to the transmit pointer register. That write copies the window into the next free queue entry. The protocol engine then sees the oldest unsent frame on a valid/done handshake.

Received frames are pushed in by the protocol engine. Software reads the oldest one through the receive window and writes 0xFF to the receive pointer register to drop it and expose the next. Each control register reports a queue's state: the unsent count for transmit, an empty flag for receive. Two interrupt status bits, gated by matching enable bits, tell an interrupt controller about queue activity. A receive overrun strobe goes toward the error logic.

Top module: `can_fifo_window`

## Requirements
- R1: After reset both queues are disabled and empty. The transmit control register (0x400) reads 0x00, the receive control register (0x402) reads 0x80, and the status (0x405) and enable (0x404) registers read 0x00. tx_valid, irq_tx, irq_rx and rx_overrun are low.
- R2: The transmit window occupies bytes 0x380-0x38F (mailbox 56 × 16) and the receive window occupies 0x3C0-0x3CF (mailbox 60 × 16). Window byte offsets map as follows:
  - 0 to 3 hold ID word bits 31:24, 23:16, 15:8 and 7:0.
  - 4 reads 0 and ignores writes.
  - 5 holds the length code in bits 3:0, with bits 7:4 reading 0.
  - 6 to 13 hold data bytes 0 to 7. Data byte k is bits 8k+7:8k of the data bus.
  - 14 and 15 hold timestamp bits 15:8 and 7:0.
- R3: When transmit is enabled (bit 0 of 0x400), writing 0xFF to 0x401 appends the window contents to the transmit queue. The unsent count in bits 3:1 of 0x400 then rises by one. Any other value written to 0x401 has no effect.
- R4: A commit while the transmit queue already holds DEPTH (4) frames is ignored. The count stays 4 and the queued frames are unchanged.
- R5: tx_valid is high while the transmit queue is non-empty, and the tx_* frame outputs show the oldest committed frame. A tx_done pulse removes it and lowers the count by one. tx_done on an empty queue has no effect.
- R6: When receive is enabled (bit 0 of 0x402), an rx_push appends the rx_* frame. The receive window shows the oldest stored frame. Bit 7 of 0x402 reads 1 exactly while the receive queue is empty.
- R7: Writing 0xFF to 0x403 releases the oldest receive frame. A release on an empty queue, or any other value written to 0x403, has no effect.
- R8: An rx_push onto a full receive queue with no same-cycle release overwrites the oldest frame. rx_overrun is high for the one cycle that follows.
- R9: Status bit 4 of 0x405 sets on every accepted rx_push, and status bit 3 sets on every tx_done that removes a frame. Writing 0 to either bit clears it and writing 1 leaves it unchanged. irq_rx is status bit 4 ANDed with enable bit 4 of 0x404, and irq_tx is status bit 3 ANDed with enable bit 3.
- R10: Clearing a queue's enable bit empties that queue at once. While a queue is disabled, commits, rx_push and releases have no effect, and rx_push does not set status bit 4.
- R11: The ID word is stored and shown unchanged, so its layout is kept:
  - bit 31 is the extended flag;
  - bit 30 is the remote-request flag;
  - a standard ID occupies bits 28:18;
  - an extended ID occupies bits 28:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_addr | input | 11 | CPU byte address |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data for cpu_addr |
| tx_valid | output | 1 | Transmit queue holds a frame |
| tx_id | output | 32 | Oldest transmit frame ID word |
| tx_dlc | output | 4 | Oldest transmit frame length code |
| tx_data | output | 64 | Oldest transmit frame data bytes |
| tx_stamp | output | 16 | Oldest transmit frame timestamp |
| tx_done | input | 1 | Oldest transmit frame has been sent |
| rx_push | input | 1 | Received frame strobe |
| rx_id | input | 32 | Received ID word |
| rx_dlc | input | 4 | Received length code |
| rx_data | input | 64 | Received data bytes |
| rx_stamp | input | 16 | Received timestamp |
| rx_overrun | output | 1 | One-cycle pulse when an unread frame was overwritten |
| irq_tx | output | 1 | Gated transmit queue interrupt |
| irq_rx | output | 1 | Gated receive queue interrupt |

## Verification
A corrupted pointer or count shows up on the first register read after the faulty edge. It appears as a wrong unsent count or empty flag, or as the window or tx_* outputs showing a frame out of commit order. Every frame carries values derived from its sequence number, so a swapped or overwritten entry is detected as soon as it is shown. The bench fills each queue past its depth and drains it one entry at a time, checking every fill level, the overrun strobe and the interrupt flags on the cycle after each event.

// File: rtl/cfw_pkg.sv
package cfw_pkg;

  typedef struct packed {
    logic [31:0] id;
    logic [3:0]  dlc;
    logic [63:0] data;
    logic [15:0] ts;
  } frame_t;

  localparam int FRAME_W   = $bits(frame_t);
  localparam int MBX_BYTES = 16;
  localparam int MBX_SH    = 4;
  localparam logic [7:0] PTR_KEY = 8'hFF;
  localparam int IRQ_RX_BIT = 4;
  localparam int IRQ_TX_BIT = 3;
  localparam int RX_EMPTY_BIT = 7;

  function automatic logic [7:0] frame_byte(input frame_t f, input logic [3:0] off);
    logic [7:0] b;
    int idx;
    idx = int'(off) - 6;
    case (off)
      4'd0:  b = f.id[31:24];
      4'd1:  b = f.id[23:16];
      4'd2:  b = f.id[15:8];
      4'd3:  b = f.id[7:0];
      4'd4:  b = 8'h00;
      4'd5:  b = {4'h0, f.dlc};
      4'd14: b = f.ts[15:8];
      4'd15: b = f.ts[7:0];
      default: b = f.data[8*idx +: 8];
    endcase
    return b;
  endfunction

  function automatic frame_t frame_put(input frame_t f, input logic [3:0] off,
                                       input logic [7:0] b);
    frame_t r;
    int idx;
    r = f;
    idx = int'(off) - 6;
    case (off)
      4'd0:  r.id[31:24] = b;
      4'd1:  r.id[23:16] = b;
      4'd2:  r.id[15:8]  = b;
      4'd3:  r.id[7:0]   = b;
      4'd4:  r = f;
      4'd5:  r.dlc = b[3:0];
      4'd14: r.ts[15:8] = b;
      4'd15: r.ts[7:0]  = b;
      default: r.data[8*idx +: 8] = b;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cfw_ring.sv
module cfw_ring #(
  parameter int DEPTH     = 4,
  parameter int WIDTH     = 116,
  parameter bit OVERWRITE = 1'b0,
  localparam int PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [CNT_W-1:0] cnt,
  output logic             empty,
  output logic             full,
  output logic             dropped
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] head_q, head_n, tail_q, tail_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             do_pop, do_push, do_drop, adv_head;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_W'(DEPTH));

  always_comb begin
    do_pop   = pop && !empty && !flush;
    do_drop  = push && full && !do_pop && OVERWRITE && !flush;
    do_push  = push && !flush && (!full || do_pop || OVERWRITE);
    adv_head = do_pop || do_drop;
    head_n   = head_q;
    tail_n   = tail_q;
    cnt_n    = cnt_q;
    if (flush) begin
      head_n = '0;
      tail_n = '0;
      cnt_n  = '0;
    end else begin
      if (adv_head) head_n = ptr_inc(head_q);
      if (do_push)  tail_n = ptr_inc(tail_q);
      if (do_push && !adv_head)      cnt_n = cnt_q + CNT_W'(1);
      else if (!do_push && adv_head) cnt_n = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_n;
      tail_q <= tail_n;
      cnt_q  <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[tail_q] <= din;
  end

  assign dout    = empty ? '0 : mem[head_q];
  assign cnt     = cnt_q;
  assign dropped = do_drop;

  // R4: occupancy never exceeds the depth
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  // R7: removal from an empty ring leaves the read pointer where it was
  p_empty_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push && !flush) |=> (head_q == $past(head_q)) && (cnt_q == '0));

endmodule

// File: rtl/cfw_irq.sv
module cfw_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_tx,
  input  logic       ev_rx,
  input  logic       wr_stat,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] stat_rd,
  output logic [7:0] en_rd,
  output logic       irq_tx,
  output logic       irq_rx
);
  import cfw_pkg::*;

  logic st_tx_q, st_tx_n, st_rx_q, st_rx_n;
  logic en_tx_q, en_tx_n, en_rx_q, en_rx_n;

  always_comb begin
    st_tx_n = (st_tx_q && !(wr_stat && !wdata[IRQ_TX_BIT])) || ev_tx;
    st_rx_n = (st_rx_q && !(wr_stat && !wdata[IRQ_RX_BIT])) || ev_rx;
    en_tx_n = wr_en ? wdata[IRQ_TX_BIT] : en_tx_q;
    en_rx_n = wr_en ? wdata[IRQ_RX_BIT] : en_rx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_tx_q <= 1'b0;
      st_rx_q <= 1'b0;
      en_tx_q <= 1'b0;
      en_rx_q <= 1'b0;
    end else begin
      st_tx_q <= st_tx_n;
      st_rx_q <= st_rx_n;
      en_tx_q <= en_tx_n;
      en_rx_q <= en_rx_n;
    end
  end

  always_comb begin
    stat_rd = 8'h00;
    stat_rd[IRQ_TX_BIT] = st_tx_q;
    stat_rd[IRQ_RX_BIT] = st_rx_q;
    en_rd = 8'h00;
    en_rd[IRQ_TX_BIT] = en_tx_q;
    en_rd[IRQ_RX_BIT] = en_rx_q;
  end

  assign irq_tx = st_tx_q && en_tx_q;
  assign irq_rx = st_rx_q && en_rx_q;

  // R9: an event always leaves its status bit set on the next cycle
  p_ev_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx |=> st_rx_q);

  // R9: without an event or a clearing write the status bit holds
  p_stat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_tx && !wr_stat) |=> $stable(st_tx_q));

endmodule

// File: rtl/can_fifo_window.sv
module can_fifo_window #(
  parameter int ADDR_W   = 11,
  parameter int DEPTH    = 4,
  parameter int TX_MBX   = 56,
  parameter int RX_MBX   = 60,
  parameter int CTL_BASE = 'h400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  output logic              tx_valid,
  output logic [31:0]       tx_id,
  output logic [3:0]        tx_dlc,
  output logic [63:0]       tx_data,
  output logic [15:0]       tx_stamp,
  input  logic              tx_done,
  input  logic              rx_push,
  input  logic [31:0]       rx_id,
  input  logic [3:0]        rx_dlc,
  input  logic [63:0]       rx_data,
  input  logic [15:0]       rx_stamp,
  output logic              rx_overrun,
  output logic              irq_tx,
  output logic              irq_rx
);
  import cfw_pkg::*;

  localparam int CNT_W   = $clog2(DEPTH + 1);
  localparam int MBXI_W  = ADDR_W - MBX_SH;
  localparam logic [ADDR_W-1:0] A_TXCTL = ADDR_W'(CTL_BASE);
  localparam logic [ADDR_W-1:0] A_TXPTR = ADDR_W'(CTL_BASE + 1);
  localparam logic [ADDR_W-1:0] A_RXCTL = ADDR_W'(CTL_BASE + 2);
  localparam logic [ADDR_W-1:0] A_RXPTR = ADDR_W'(CTL_BASE + 3);
  localparam logic [ADDR_W-1:0] A_IEN   = ADDR_W'(CTL_BASE + 4);
  localparam logic [ADDR_W-1:0] A_ISTAT = ADDR_W'(CTL_BASE + 5);

  // reset: asynchronous assert, two-stage synchronous release
  logic rst_s1_q, rst_s2_q, rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_i_n = rst_s2_q;

  // address decode
  logic [3:0] off;
  logic tx_win, rx_win, wr_txctl, wr_rxctl, wr_ien, wr_istat;
  logic tx_commit_key, rx_release_key;
  assign off      = cpu_addr[MBX_SH-1:0];
  assign tx_win   = (cpu_addr[ADDR_W-1:MBX_SH] == MBXI_W'(TX_MBX));
  assign rx_win   = (cpu_addr[ADDR_W-1:MBX_SH] == MBXI_W'(RX_MBX));
  assign wr_txctl = cpu_wr && (cpu_addr == A_TXCTL);
  assign wr_rxctl = cpu_wr && (cpu_addr == A_RXCTL);
  assign wr_ien   = cpu_wr && (cpu_addr == A_IEN);
  assign wr_istat = cpu_wr && (cpu_addr == A_ISTAT);
  assign tx_commit_key  = cpu_wr && (cpu_addr == A_TXPTR) && (cpu_wdata == PTR_KEY);
  assign rx_release_key = cpu_wr && (cpu_addr == A_RXPTR) && (cpu_wdata == PTR_KEY);

  // enables
  logic tx_en_q, tx_en_n, rx_en_q, rx_en_n;
  always_comb begin
    tx_en_n = wr_txctl ? cpu_wdata[0] : tx_en_q;
    rx_en_n = wr_rxctl ? cpu_wdata[0] : rx_en_q;
  end
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      tx_en_q <= 1'b0;
      rx_en_q <= 1'b0;
    end else begin
      tx_en_q <= tx_en_n;
      rx_en_q <= rx_en_n;
    end
  end

  // transmit staging window
  frame_t stage_q, stage_n;
  logic   stage_we;
  assign stage_we = cpu_wr && tx_win;
  always_comb stage_n = frame_put(stage_q, off, cpu_wdata);
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)      stage_q <= '0;
    else if (stage_we) stage_q <= stage_n;
  end

  // transmit queue
  logic             tx_flush, tx_push, tx_pop, tx_empty, tx_full, tx_drop_unused;
  logic [CNT_W-1:0] tx_cnt;
  frame_t           tx_head;
  assign tx_flush = !tx_en_n;
  assign tx_push  = tx_commit_key && tx_en_q;
  assign tx_pop   = tx_done && tx_en_q;

  cfw_ring #(.DEPTH(DEPTH), .WIDTH(FRAME_W), .OVERWRITE(1'b0)) u_tx_ring (
    .clk(clk), .rst_n(rst_i_n), .flush(tx_flush), .push(tx_push), .pop(tx_pop),
    .din(stage_q), .dout(tx_head), .cnt(tx_cnt), .empty(tx_empty),
    .full(tx_full), .dropped(tx_drop_unused));

  assign tx_valid = !tx_empty;
  assign tx_id    = tx_head.id;
  assign tx_dlc   = tx_head.dlc;
  assign tx_data  = tx_head.data;
  assign tx_stamp = tx_head.ts;

  // receive queue
  logic             rx_flush, rx_acc, rx_pop, rx_empty, rx_full, rx_drop;
  logic [CNT_W-1:0] rx_cnt;
  frame_t           rx_in, rx_head;
  assign rx_in    = '{id: rx_id, dlc: rx_dlc, data: rx_data, ts: rx_stamp};
  assign rx_flush = !rx_en_n;
  assign rx_acc   = rx_push && rx_en_q;
  assign rx_pop   = rx_release_key && rx_en_q;

  cfw_ring #(.DEPTH(DEPTH), .WIDTH(FRAME_W), .OVERWRITE(1'b1)) u_rx_ring (
    .clk(clk), .rst_n(rst_i_n), .flush(rx_flush), .push(rx_acc), .pop(rx_pop),
    .din(rx_in), .dout(rx_head), .cnt(rx_cnt), .empty(rx_empty),
    .full(rx_full), .dropped(rx_drop));

  logic ovr_q;
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) ovr_q <= 1'b0;
    else          ovr_q <= rx_drop;
  end
  assign rx_overrun = ovr_q;

  // interrupt flags
  logic [7:0] stat_rd, en_rd;
  logic       ev_tx, ev_rx;
  assign ev_tx = tx_pop && !tx_empty && !tx_flush;
  assign ev_rx = rx_acc && !rx_flush;

  cfw_irq u_irq (
    .clk(clk), .rst_n(rst_i_n), .ev_tx(ev_tx), .ev_rx(ev_rx),
    .wr_stat(wr_istat), .wr_en(wr_ien), .wdata(cpu_wdata),
    .stat_rd(stat_rd), .en_rd(en_rd), .irq_tx(irq_tx), .irq_rx(irq_rx));

  // read mux
  logic [2:0] unsent;
  assign unsent = 3'(tx_cnt);
  always_comb begin
    cpu_rdata = 8'h00;
    if (tx_win)                    cpu_rdata = frame_byte(stage_q, off);
    else if (rx_win)               cpu_rdata = frame_byte(rx_head, off);
    else if (cpu_addr == A_TXCTL)  cpu_rdata = {4'h0, unsent, tx_en_q};
    else if (cpu_addr == A_RXCTL)  cpu_rdata = {rx_empty, 6'h00, rx_en_q};
    else if (cpu_addr == A_IEN)    cpu_rdata = en_rd;
    else if (cpu_addr == A_ISTAT)  cpu_rdata = stat_rd;
  end

  // R4: commit into a full queue with nothing leaving keeps it full
  p_full_commit_r4: assert property (@(posedge clk) disable iff (!rst_i_n)
    (tx_push && tx_full && !tx_done && tx_en_n) |=> (tx_cnt == CNT_W'(DEPTH)));

  // R8: a push that finds the queue full with no release raises the strobe
  p_overrun_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rx_acc && rx_full && !rx_release_key && rx_en_n) |=> rx_overrun);

  // R10: a disabled queue stays empty
  p_disabled_empty_r10: assert property (@(posedge clk) disable iff (!rst_i_n)
    !tx_en_q |-> (tx_cnt == '0) && !tx_valid);

  // R5: a completion on a non-empty queue lowers the unsent count
  p_done_drains_r5: assert property (@(posedge clk) disable iff (!rst_i_n)
    (tx_done && tx_valid && !tx_commit_key && tx_en_n) |=> (tx_cnt == $past(tx_cnt) - CNT_W'(1)));

endmodule

// File: tb/tb_can_fifo_window.sv
module tb_can_fifo_window;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] cpu_addr = '0;
  logic        cpu_wr = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        tx_valid, tx_done = 1'b0;
  logic [31:0] tx_id;
  logic [3:0]  tx_dlc;
  logic [63:0] tx_data;
  logic [15:0] tx_stamp;
  logic        rx_push = 1'b0;
  logic [31:0] rx_id = '0;
  logic [3:0]  rx_dlc = '0;
  logic [63:0] rx_data = '0;
  logic [15:0] rx_stamp = '0;
  logic        rx_overrun, irq_tx, irq_rx;

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 1'b0;

  localparam logic [10:0] TXW = 11'h380, RXW = 11'h3C0;
  localparam logic [10:0] TXCTL = 11'h400, TXPTR = 11'h401, RXCTL = 11'h402,
                          RXPTR = 11'h403, IEN = 11'h404, ISTAT = 11'h405;

  always #2.5 clk = ~clk;

  can_fifo_window dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .tx_valid(tx_valid),
    .tx_id(tx_id), .tx_dlc(tx_dlc), .tx_data(tx_data), .tx_stamp(tx_stamp),
    .tx_done(tx_done), .rx_push(rx_push), .rx_id(rx_id), .rx_dlc(rx_dlc),
    .rx_data(rx_data), .rx_stamp(rx_stamp), .rx_overrun(rx_overrun),
    .irq_tx(irq_tx), .irq_rx(irq_rx));

  // frame n derived arithmetically
  function automatic logic [31:0] f_id(input int n);
    logic [31:0] v;
    if (n % 2 == 1) v = 32'h8000_0000 | ((32'(n) * 32'h0123_4567) & 32'h1FFF_FFFF);
    else            v = 32'(((n * 37 + 5) & 32'h7FF)) << 18;
    if (n % 3 == 0) v = v | 32'h4000_0000;
    return v;
  endfunction
  function automatic logic [3:0] f_dlc(input int n);  return 4'(n % 9); endfunction
  function automatic logic [7:0] f_db(input int n, input int k); return 8'(n * 16 + k); endfunction
  function automatic logic [15:0] f_ts(input int n); return 16'(n * 257 + 3); endfunction
  function automatic logic [63:0] f_data(input int n);
    logic [63:0] d;
    for (int k = 0; k < 8; k++) d[8*k +: 8] = f_db(n, k);
    return d;
  endfunction
  function automatic logic [7:0] exp_byte(input int n, input int off);
    logic [31:0] id;
    id = f_id(n);
    case (off)
      0: return id[31:24];
      1: return id[23:16];
      2: return id[15:8];
      3: return id[7:0];
      4: return 8'h00;
      5: return {4'h0, f_dlc(n)};
      14: return f_ts(n) >> 8;
      15: return f_ts(n) & 16'hFF;
      default: return f_db(n, off - 6);
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic rd(input logic [10:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wr = 1'b0;
    #1 d = cpu_rdata;
  endtask

  task automatic load_tx(input int n);
    for (int o = 0; o < 16; o++) begin
      logic [7:0] b;
      b = exp_byte(n, o);
      if (o == 5) b = b | 8'hF0;
      if (o == 4) b = 8'hA5;
      wr(TXW + 11'(o), b);
    end
  endtask

  task automatic pulse_done();
    @(negedge clk); tx_done = 1'b1;
    @(negedge clk); tx_done = 1'b0;
  endtask

  task automatic push_rx(input int n);
    @(negedge clk);
    rx_push = 1'b1; rx_id = f_id(n); rx_dlc = f_dlc(n); rx_data = f_data(n); rx_stamp = f_ts(n);
    @(negedge clk);
    rx_push = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(TXCTL, d); chk(d == 8'h00, "R1 txctl", d, 8'h00);
    rd(RXCTL, d); chk(d == 8'h80, "R1 rxctl", d, 8'h80);
    rd(ISTAT, d); chk(d == 8'h00, "R1 istat", d, 0);
    rd(IEN, d);   chk(d == 8'h00, "R1 ien", d, 0);
    chk(!tx_valid && !irq_tx && !irq_rx && !rx_overrun, "R1 outputs",
        {tx_valid, irq_tx, irq_rx, rx_overrun}, 0);

    // R10 commit while disabled ignored
    load_tx(1);
    wr(TXPTR, 8'hFF);
    rd(TXCTL, d); chk(d == 8'h00, "R10 commit disabled", d, 0);

    // R2 transmit window readback
    for (int o = 0; o < 16; o++) begin
      rd(TXW + 11'(o), d);
      chk(d == exp_byte(1, o), "R2 tx window byte", d, exp_byte(1, o));
    end

    wr(IEN, 8'h18);
    rd(IEN, d); chk(d == 8'h18, "R9 ien readback", d, 8'h18);
    wr(TXCTL, 8'h01);

    // R3 R4 fill sweep beyond depth
    for (int n = 0; n < 6; n++) begin
      int e;
      load_tx(n);
      wr(TXPTR, 8'h7F);
      rd(TXCTL, d);
      e = (n < 4) ? n : 4;
      chk(d == 8'((e << 1) | 1), "R3 non-key ignored", d, (e << 1) | 1);
      wr(TXPTR, 8'hFF);
      rd(TXCTL, d);
      e = (n + 1 < 4) ? n + 1 : 4;
      chk(d == 8'((e << 1) | 1), (n >= 4) ? "R4 full commit ignored" : "R3 unsent count",
          d, (e << 1) | 1);
    end

    // R5 R11 drain in order
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      chk(tx_valid, "R5 valid", tx_valid, 1);
      chk(tx_id == f_id(n), "R11 tx id word", tx_id, f_id(n));
      chk(tx_dlc == f_dlc(n) && tx_stamp == f_ts(n), "R5 dlc stamp",
          {tx_dlc, tx_stamp}, {f_dlc(n), f_ts(n)});
      chk(tx_data == f_data(n), "R5 data order", tx_data, f_data(n));
      pulse_done();
      rd(TXCTL, d);
      chk(d == 8'(((3 - n) << 1) | 1), "R5 count after done", d, ((3 - n) << 1) | 1);
    end
    chk(!tx_valid, "R5 empty after drain", tx_valid, 0);
    rd(ISTAT, d); chk(d == 8'h08, "R9 tx status set", d, 8'h08);
    chk(irq_tx, "R9 irq_tx gated", irq_tx, 1);
    pulse_done();
    rd(TXCTL, d); chk(d == 8'h01, "R5 done on empty ignored", d, 8'h01);

    // R6 R8 receive fill sweep with overrun
    wr(RXCTL, 8'h01);
    rd(RXCTL, d); chk(d == 8'h81, "R6 empty flag", d, 8'h81);
    for (int n = 0; n < 6; n++) begin
      push_rx(10 + n);
      chk(rx_overrun == (n >= 4), "R8 overrun strobe", rx_overrun, n >= 4);
      rd(RXCTL, d); chk(d == 8'h01, "R6 not empty", d, 8'h01);
      chk(!rx_overrun, "R8 strobe one cycle", rx_overrun, 0);
    end
    rd(ISTAT, d); chk(d == 8'h18, "R9 rx status set", d, 8'h18);
    chk(irq_rx, "R9 irq_rx", irq_rx, 1);

    // R7 R2 R11 read and release, oldest is frame 12
    for (int n = 0; n < 4; n++) begin
      for (int o = 0; o < 16; o++) begin
        rd(RXW + 11'(o), d);
        chk(d == exp_byte(12 + n, o), "R2 rx window byte", d, exp_byte(12 + n, o));
      end
      wr(RXPTR, 8'h00);
      rd(RXW, d); chk(d == exp_byte(12 + n, 0), "R7 non-key release ignored", d, exp_byte(12 + n, 0));
      wr(RXW + 11'd1, 8'h5A);
      rd(RXW + 11'd1, d); chk(d == exp_byte(12 + n, 1), "R2 rx window write ignored", d, exp_byte(12 + n, 1));
      wr(RXPTR, 8'hFF);
    end
    rd(RXCTL, d); chk(d == 8'h81, "R6 empty after release", d, 8'h81);
    wr(RXPTR, 8'hFF);
    push_rx(30);
    rd(RXW + 11'd3, d); chk(d == exp_byte(30, 3), "R7 empty release ignored", d, exp_byte(30, 3));
    rd(RXCTL, d); chk(d == 8'h01, "R7 count one", d, 8'h01);
    wr(RXPTR, 8'hFF);

    // R9 write-zero clear
    wr(ISTAT, 8'hEF);
    rd(ISTAT, d); chk(d == 8'h08, "R9 clear rx keeps tx", d, 8'h08);
    chk(!irq_rx && irq_tx, "R9 irq after clear", {irq_rx, irq_tx}, 2'b01);
    wr(ISTAT, 8'hF7);
    rd(ISTAT, d); chk(d == 8'h00, "R9 clear tx", d, 0);
    wr(IEN, 8'h00);
    push_rx(31);
    chk(!irq_rx, "R9 irq gated by enable", irq_rx, 0);
    wr(RXPTR, 8'hFF);

    // R10 disable flushes and ignores
    load_tx(7);
    wr(TXPTR, 8'hFF); wr(TXPTR, 8'hFF);
    rd(TXCTL, d); chk(d == 8'h05, "R10 before disable", d, 8'h05);
    wr(TXCTL, 8'h00);
    rd(TXCTL, d); chk(d == 8'h00, "R10 tx flushed", d, 0);
    chk(!tx_valid, "R10 tx_valid low", tx_valid, 0);
    push_rx(40); push_rx(41);
    wr(RXCTL, 8'h00);
    wr(ISTAT, 8'h00);
    push_rx(42);
    rd(RXCTL, d); chk(d == 8'h80, "R10 rx disabled push ignored", d, 8'h80);
    rd(ISTAT, d); chk(d == 8'h00, "R10 no rx status", d, 0);

    done_flag = 1'b1;
    finish_run();
  end

endmodule